// File: doc/BRIEF.md
# Dual-Bank Asynchronous SRAM Controller

This block sits between a simple synchronous memory-mapped master and two external asynchronous SRAM banks. Each bank is 32 bits wide, built from two 16-bit devices side by side, and has its own word address, data pads, output enable and write enable. The devices' chip enables and byte-lane enables are tied active on the board. The only way to pick a bank is therefore to gate its own output-enable and write-enable strobes, and every write to a device stores the whole 32-bit word.

The master presents a byte address, a select, read and write strobes, byte enables and write data. It holds them until the wait output drops. The controller takes bit 18 of the byte address as the bank bit and bits 17 down to 2 as the word address. It sequences the active-low strobes from registers and returns registered read data. A write whose byte enables are not all set is carried out as a read of the word, a merge of the enabled bytes and a full-word write-back. Read and write strobe widths each stretch by a parameter of 0 or 1 extra cycle. Data pads are brought out as output value, output enable and input value, so the pad ring at the chip top forms the tristate buffer.

Top module: `sram2bank_ctrl`

## Requirements
- R1: Byte-address bit 18 selects the bank (0 picks bank 0, 1 picks bank 1). Only the selected bank's strobes or data enable ever go active, and the other bank's stored words are untouched.
- R2: The word address on the selected bank's address pins equals byte-address bits 17:2. Byte-address bits 1:0 have no effect on the word reached.
- R3: On each bank, output enable and write enable are never low in the same cycle. No two banks have any strobe low in the same cycle.
- R4: A write with all four byte enables set stores the full 32-bit write data, and a later read of that word returns it.
- R5: A write with any byte enable clear is a read-modify-write. Byte enable bit i set takes write-data bits 8i+7:8i, and clear keeps the stored byte. With all enables clear the word is unchanged.
- R6: A read keeps wait high for 2 + RD_WAIT sampled cycles. It then drops wait for one cycle, with the word on the read-data output.
- R7: A full write keeps wait high for 4 + WR_WAIT cycles. A read-modify-write keeps it high for 5 + RD_WAIT + WR_WAIT cycles.
- R8: A bank's data output enable is high only while its write enable is low or in the one cycle after it rises. It is never high while its output enable is low. Write data is valid when write enable rises.
- R9: A bank's address pins hold the same value in the cycle before write enable falls, throughout the strobe and in the cycle after it rises.
- R10: Reset drives all strobes high and all data output enables low on the next clock. It abandons an access in progress without writing the SRAM.
- R11: With no select, or with select but neither read nor write, wait is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Master select |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request (wins over read) |
| bus_addr | input | 19 | Byte address |
| bus_be | input | 4 | Byte enables, bit i for byte i |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_wait | output | 1 | High while the request is not yet complete |
| sram0_addr | output | 16 | Bank 0 word address |
| sram0_dq_o | output | 32 | Bank 0 data to pads |
| sram0_dq_oe | output | 1 | Bank 0 data pad output enable |
| sram0_dq_i | input | 32 | Bank 0 data from pads |
| sram0_oe_n | output | 1 | Bank 0 output enable, active low |
| sram0_we_n | output | 1 | Bank 0 write enable, active low |
| sram1_addr | output | 16 | Bank 1 word address |
| sram1_dq_o | output | 32 | Bank 1 data to pads |
| sram1_dq_oe | output | 1 | Bank 1 data pad output enable |
| sram1_dq_i | input | 32 | Bank 1 data from pads |
| sram1_oe_n | output | 1 | Bank 1 output enable, active low |
| sram1_we_n | output | 1 | Bank 1 write enable, active low |

## Verification
In a partial write, the capture of the old word and the merge of the new bytes fall in the same cycle, the last read-strobe cycle, which also turns the bus toward writing. The bench provokes this with byte-enable patterns 0101 and 0000 on a word that holds known data. It judges the result by reading the word back against a byte-merged scoreboard and by counting wait cycles against the read-modify-write formula. Every clock it also checks that the data enable never overlaps the output enable, and it aborts one such sequence by reset in the middle of its read phase.

// File: rtl/sram2bank_pkg.sv
package sram2bank_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_WSET,
    S_WR,
    S_WHOLD,
    S_DONE
  } seq_state_t;
endpackage

// File: rtl/sram2bank_merge.sv
module sram2bank_merge #(
  parameter int DATA_W = 32,
  localparam int BE_W = DATA_W / 8
) (
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] new_word,
  input  logic [BE_W-1:0]   be,
  output logic [DATA_W-1:0] merged
);
  for (genvar i = 0; i < BE_W; i++) begin : g_lane
    assign merged[8*i +: 8] = be[i] ? new_word[8*i +: 8] : old_word[8*i +: 8];
  end
endmodule

// File: rtl/sram2bank_seq.sv
module sram2bank_seq
  import sram2bank_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int WADDR_W = 16,
  parameter int RD_WAIT = 1,
  parameter int WR_WAIT = 1,
  localparam int BE_W   = DATA_W / 8,
  localparam int CNT_W  = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req,
  input  logic                   req_wr,
  input  logic                   req_bank,
  input  logic [WADDR_W-1:0]     req_waddr,
  input  logic [BE_W-1:0]        req_be,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [1:0][DATA_W-1:0] bank_dq,
  output logic                   cmd_oe,
  output logic                   cmd_we,
  output logic                   cmd_drv,
  output logic                   cmd_bank,
  output logic [WADDR_W-1:0]     waddr_q,
  output logic [DATA_W-1:0]      wword_q,
  output logic [DATA_W-1:0]      rdata_q,
  output logic                   done
);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_WAIT);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_WAIT);

  seq_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              bank_q, op_wr_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] old_word, merged;
  logic              take, rd_last;

  assign take    = (state_q == S_IDLE) && req;
  assign rd_last = (state_q == S_RD) && (cnt_q == RD_LAST);
  assign old_word = bank_dq[bank_q];

  sram2bank_merge #(.DATA_W(DATA_W)) u_merge (
    .old_word(old_word), .new_word(wword_q), .be(be_q), .merged(merged)
  );

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      S_IDLE: if (req) begin
        cnt_d   = '0;
        state_d = (req_wr && (&req_be)) ? S_WSET : S_RD;
      end
      S_RD: if (cnt_q == RD_LAST) begin
        cnt_d   = '0;
        state_d = op_wr_q ? S_WSET : S_DONE;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
      S_WSET: begin
        cnt_d   = '0;
        state_d = S_WR;
      end
      S_WR: if (cnt_q == WR_LAST) state_d = S_WHOLD;
            else cnt_d = cnt_q + CNT_W'(1);
      S_WHOLD: state_d = S_DONE;
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // Commands describe the next cycle so the pin flops follow the state exactly.
  assign cmd_oe   = (state_d == S_RD);
  assign cmd_we   = (state_d == S_WR);
  assign cmd_drv  = (state_d == S_WR) || (state_d == S_WHOLD);
  assign cmd_bank = take ? req_bank : bank_q;
  assign done     = (state_q == S_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      bank_q  <= 1'b0;
      op_wr_q <= 1'b0;
      be_q    <= '0;
      waddr_q <= '0;
      wword_q <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (take) begin
        bank_q  <= req_bank;
        op_wr_q <= req_wr;
        be_q    <= req_be;
        waddr_q <= req_waddr;
        wword_q <= req_wdata;
      end
      if (rd_last) begin
        rdata_q <= old_word;
        if (op_wr_q) wword_q <= merged;
      end
    end
  end

  // R5: a partial write reaches the write setup only through the read phase
  assert_rmw_reads_first_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_WSET && !(&be_q)) |-> ($past(state_q) == S_RD));
endmodule

// File: rtl/sram2bank_bank_port.sv
module sram2bank_bank_port #(
  parameter int BANK_IDX = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_oe,
  input  logic cmd_we,
  input  logic cmd_drv,
  input  logic cmd_bank,
  output logic oe_n_q,
  output logic we_n_q,
  output logic drv_q
);
  logic mine;
  assign mine = (cmd_bank == 1'(BANK_IDX));

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_n_q <= 1'b1;
      we_n_q <= 1'b1;
      drv_q  <= 1'b0;
    end else begin
      oe_n_q <= ~(cmd_oe & mine);
      we_n_q <= ~(cmd_we & mine);
      drv_q  <= cmd_drv & mine;
    end
  end

  assert_no_oe_we_overlap_R3: assert property (@(posedge clk) disable iff (rst)
    !(!oe_n_q && !we_n_q));

  assert_drive_window_R8: assert property (@(posedge clk) disable iff (rst)
    drv_q |-> (!we_n_q || !$past(we_n_q)));

  assert_no_drive_on_read_R8: assert property (@(posedge clk) disable iff (rst)
    drv_q |-> oe_n_q);

  assert_reset_quiet_R10: assert property (@(posedge clk)
    rst |=> (oe_n_q && we_n_q && !drv_q));
endmodule

// File: rtl/sram2bank_ctrl.sv
module sram2bank_ctrl
  import sram2bank_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int WADDR_W = 16,
  parameter int RD_WAIT = 1,
  parameter int WR_WAIT = 1,
  localparam int BE_W    = DATA_W / 8,
  localparam int BADDR_W = WADDR_W + 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_cs,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [BADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]    bus_be,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_wait,
  output logic [WADDR_W-1:0] sram0_addr,
  output logic [DATA_W-1:0]  sram0_dq_o,
  output logic               sram0_dq_oe,
  input  logic [DATA_W-1:0]  sram0_dq_i,
  output logic               sram0_oe_n,
  output logic               sram0_we_n,
  output logic [WADDR_W-1:0] sram1_addr,
  output logic [DATA_W-1:0]  sram1_dq_o,
  output logic               sram1_dq_oe,
  input  logic [DATA_W-1:0]  sram1_dq_i,
  output logic               sram1_oe_n,
  output logic               sram1_we_n
);
  logic                   req, seq_done;
  logic                   cmd_oe, cmd_we, cmd_drv, cmd_bank;
  logic [WADDR_W-1:0]     waddr_q;
  logic [DATA_W-1:0]      wword_q;
  logic [1:0][DATA_W-1:0] bank_dq;
  logic [1:0]             oe_n_a, we_n_a, drv_a;
  logic                   unused_lowbits;

  assign req            = bus_cs & (bus_rd | bus_wr);
  assign bus_wait       = req & ~seq_done;
  assign unused_lowbits = ^bus_addr[1:0];
  assign bank_dq[0]     = sram0_dq_i;
  assign bank_dq[1]     = sram1_dq_i;

  sram2bank_seq #(
    .DATA_W(DATA_W), .WADDR_W(WADDR_W), .RD_WAIT(RD_WAIT), .WR_WAIT(WR_WAIT)
  ) u_seq (
    .clk(clk), .rst(rst), .req(req), .req_wr(bus_wr),
    .req_bank(bus_addr[WADDR_W+2]), .req_waddr(bus_addr[WADDR_W+1:2]),
    .req_be(bus_be), .req_wdata(bus_wdata), .bank_dq(bank_dq),
    .cmd_oe(cmd_oe), .cmd_we(cmd_we), .cmd_drv(cmd_drv), .cmd_bank(cmd_bank),
    .waddr_q(waddr_q), .wword_q(wword_q), .rdata_q(bus_rdata), .done(seq_done)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    sram2bank_bank_port #(.BANK_IDX(b)) u_port (
      .clk(clk), .rst(rst), .cmd_oe(cmd_oe), .cmd_we(cmd_we),
      .cmd_drv(cmd_drv), .cmd_bank(cmd_bank),
      .oe_n_q(oe_n_a[b]), .we_n_q(we_n_a[b]), .drv_q(drv_a[b])
    );
  end

  assign sram0_addr  = waddr_q;
  assign sram1_addr  = waddr_q;
  assign sram0_dq_o  = wword_q;
  assign sram1_dq_o  = wword_q;
  assign sram0_dq_oe = drv_a[0];
  assign sram1_dq_oe = drv_a[1];
  assign sram0_oe_n  = oe_n_a[0];
  assign sram1_oe_n  = oe_n_a[1];
  assign sram0_we_n  = we_n_a[0];
  assign sram1_we_n  = we_n_a[1];

  assert_one_bank_R3: assert property (@(posedge clk) disable iff (rst)
    !((!sram0_oe_n || !sram0_we_n) && (!sram1_oe_n || !sram1_we_n)));

  assert_addr_setup_R9: assert property (@(posedge clk) disable iff (rst)
    ($fell(sram0_we_n) || $fell(sram1_we_n)) |-> $stable(waddr_q));

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    ($rose(sram0_we_n) || $rose(sram1_we_n)) |-> $stable(waddr_q));

  assert_wdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(sram0_we_n) || $rose(sram1_we_n)) |-> $stable(wword_q));
endmodule

// File: tb/sram2bank_ctrl_bench.sv
module sram2bank_ctrl_bench;
  localparam int RDW = 1;
  localparam int WRW = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [18:0] addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        waitr;
  logic [15:0] a0, a1;
  logic [31:0] do0, do1, q0, q1;
  logic        dqe0, dqe1, oe0, we0, oe1, we1;

  int total = 0, errors = 0;
  bit finished = 1'b0;
  int cur_bank = 0;
  logic pwe0 = 1'b1, pwe1 = 1'b1;
  logic [15:0] pa0 = '0, pa1 = '0, last_w1 = '0;

  logic [31:0] mem0 [int];
  logic [31:0] mem1 [int];
  logic [31:0] ref0 [int];
  logic [31:0] ref1 [int];

  always #5 clk = ~clk;

  sram2bank_ctrl #(.RD_WAIT(RDW), .WR_WAIT(WRW)) u_sram2bank_ctrl (
    .clk(clk), .rst(rst), .bus_cs(cs), .bus_rd(rd), .bus_wr(wr),
    .bus_addr(addr), .bus_be(be), .bus_wdata(wdata), .bus_rdata(rdata),
    .bus_wait(waitr),
    .sram0_addr(a0), .sram0_dq_o(do0), .sram0_dq_oe(dqe0), .sram0_dq_i(q0),
    .sram0_oe_n(oe0), .sram0_we_n(we0),
    .sram1_addr(a1), .sram1_dq_o(do1), .sram1_dq_oe(dqe1), .sram1_dq_i(q1),
    .sram1_oe_n(oe1), .sram1_we_n(we1)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Asynchronous SRAM models: read value follows address, write on strobe rise.
  always @(negedge clk) begin
    q0 <= mem0.exists(int'(a0)) ? mem0[int'(a0)] : 32'h0;
    q1 <= mem1.exists(int'(a1)) ? mem1[int'(a1)] : 32'h0;
  end
  always @(posedge we0) if (!rst) begin
    chk("R8 bank0 data enabled at write strobe rise", {31'b0, dqe0}, 32'h1);
    mem0[int'(a0)] = do0;
  end
  always @(posedge we1) if (!rst) begin
    chk("R8 bank1 data enabled at write strobe rise", {31'b0, dqe1}, 32'h1);
    mem1[int'(a1)] = do1;
    last_w1 = a1;
  end

  // Per-clock pin monitor.
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3 no OE/WE overlap", {30'b0, oe0 | we0, oe1 | we1}, 32'h3);
      chk("R3 one bank at a time",
          {31'b0, (!oe0 || !we0 || dqe0) && (!oe1 || !we1 || dqe1)}, 32'h0);
      if (!oe0 || !we0 || dqe0) chk("R1 bank0 activity only when bank0 addressed", cur_bank, 0);
      if (!oe1 || !we1 || dqe1) chk("R1 bank1 activity only when bank1 addressed", cur_bank, 1);
      chk("R8 bank0 drive window", {31'b0, dqe0 && !(!we0 || !pwe0)}, 32'h0);
      chk("R8 bank1 drive window", {31'b0, dqe1 && !(!we1 || !pwe1)}, 32'h0);
      chk("R8 no drive during read", {30'b0, dqe0 && !oe0, dqe1 && !oe1}, 32'h0);
      if (we0 != pwe0) chk("R9 bank0 address stable across strobe edge", {16'b0, a0}, {16'b0, pa0});
      if (we1 != pwe1) chk("R9 bank1 address stable across strobe edge", {16'b0, a1}, {16'b0, pa1});
    end
    pwe0 <= we0; pwe1 <= we1; pa0 <= a0; pa1 <= a1;
  end

  task automatic acc(input bit w, input logic [18:0] a, input logic [3:0] b,
                     input logic [31:0] d, output logic [31:0] r, output int n);
    @(negedge clk);
    cur_bank = int'(a[18]);
    cs = 1'b1; rd = !w; wr = w; addr = a; be = b; wdata = d; n = 0;
    #1;
    while (waitr) begin
      n++;
      @(negedge clk);
      #1;
    end
    r = rdata;
    @(posedge clk);
    #1;
    cs = 1'b0; rd = 1'b0; wr = 1'b0;
  endtask

  function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] d, input logic [3:0] b);
    logic [31:0] m = o;
    for (int i = 0; i < 4; i++) if (b[i]) m[8*i +: 8] = d[8*i +: 8];
    return m;
  endfunction

  task automatic ref_wr(input logic [18:0] a, input logic [3:0] b, input logic [31:0] d);
    int k = int'(a[17:2]);
    if (a[18]) ref1[k] = mrg(ref1.exists(k) ? ref1[k] : 32'h0, d, b);
    else       ref0[k] = mrg(ref0.exists(k) ? ref0[k] : 32'h0, d, b);
  endtask

  function automatic logic [31:0] ref_rd(input logic [18:0] a);
    int k = int'(a[17:2]);
    if (a[18]) return ref1.exists(k) ? ref1[k] : 32'h0;
    return ref0.exists(k) ? ref0[k] : 32'h0;
  endfunction

  function automatic logic [18:0] ba(input bit bank, input logic [15:0] w);
    return {bank, w, 2'b00};
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; total++;
      $display("FAIL R6 watchdog expired actual=hung expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 strobes high in reset", {28'b0, oe0, we0, oe1, we1}, 32'hF);
    chk("R10 data enables low in reset", {30'b0, dqe0, dqe1}, 32'h0);
    rst = 1'b0;
    @(negedge clk); #1;
    chk("R11 wait low when idle", {31'b0, waitr}, 32'h0);
    cs = 1'b1; #1;
    chk("R11 wait low with select but no strobe", {31'b0, waitr}, 32'h0);
    rd = 1'b1; cs = 1'b0; #1;
    chk("R11 wait low with read but no select", {31'b0, waitr}, 32'h0);
    rd = 1'b0;

    acc(1, ba(0, 16'h0003), 4'hF, 32'hA5A5_0001, r, n);
    ref_wr(ba(0, 16'h0003), 4'hF, 32'hA5A5_0001);
    chk("R7 full write wait cycles", n, 4 + WRW);
    acc(0, ba(0, 16'h0003), 4'hF, 32'h0, r, n);
    chk("R4 full write read back", r, ref_rd(ba(0, 16'h0003)));
    chk("R6 read wait cycles", n, 2 + RDW);

    acc(1, ba(1, 16'h0003), 4'hF, 32'h5A5A_0002, r, n);
    ref_wr(ba(1, 16'h0003), 4'hF, 32'h5A5A_0002);
    acc(0, ba(0, 16'h0003), 4'hF, 32'h0, r, n);
    chk("R1 bank0 word untouched by bank1 write", r, 32'hA5A5_0001);
    acc(0, ba(1, 16'h0003), 4'hF, 32'h0, r, n);
    chk("R1 bank1 word read back", r, 32'h5A5A_0002);

    acc(0, ba(0, 16'h0003) | 19'h3, 4'hF, 32'h0, r, n);
    chk("R2 low byte-address bits ignored", r, 32'hA5A5_0001);

    acc(1, ba(0, 16'h0003), 4'b0101, 32'h1122_3344, r, n);
    ref_wr(ba(0, 16'h0003), 4'b0101, 32'h1122_3344);
    chk("R7 read-modify-write wait cycles", n, 5 + RDW + WRW);
    acc(0, ba(0, 16'h0003), 4'hF, 32'h0, r, n);
    chk("R5 partial write merges enabled bytes", r, 32'hA522_0044);

    acc(1, ba(0, 16'h0003), 4'b0000, 32'hFFFF_FFFF, r, n);
    chk("R5 empty byte enable wait cycles", n, 5 + RDW + WRW);
    acc(0, ba(0, 16'h0003), 4'hF, 32'h0, r, n);
    chk("R5 empty byte enable leaves word unchanged", r, 32'hA522_0044);

    acc(1, ba(1, 16'hFFFF), 4'b1010, 32'hDEAD_BEEF, r, n);
    ref_wr(ba(1, 16'hFFFF), 4'b1010, 32'hDEAD_BEEF);
    chk("R2 top word address on bank1 pins", {16'b0, last_w1}, 32'h0000_FFFF);
    acc(0, ba(1, 16'hFFFF), 4'hF, 32'h0, r, n);
    chk("R5 partial write on top word", r, ref_rd(ba(1, 16'hFFFF)));

    // Abort a read-modify-write during its read phase.
    @(negedge clk);
    cur_bank = 0;
    cs = 1'b1; wr = 1'b1; addr = ba(0, 16'h0003); be = 4'b0011; wdata = 32'h0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b1; cs = 1'b0; wr = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 strobes high after mid-access reset", {28'b0, oe0, we0, oe1, we1}, 32'hF);
    chk("R10 data enables low after mid-access reset", {30'b0, dqe0, dqe1}, 32'h0);
    rst = 1'b0;
    acc(0, ba(0, 16'h0003), 4'hF, 32'h0, r, n);
    chk("R10 abandoned write left word unchanged", r, 32'hA522_0044);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule